// File: doc/BRIEF.md
# Chip-Select Bus Cycle Sequencer

This block turns one host request into one timed access on an external parallel bus that serves a single chip-select region. The host presents an address, a direction and write data with a start pulse. The block then steps the chip enable, output enable, write enable, address and data pins through a fixed series of phases. It returns the sampled read data and pulses done. Every phase lasts a programmable number of ticks. A tick is one, two, four or eight clock cycles, selected by a two-bit scale code.

The configuration and timing inputs are captured when a request is accepted, and that copy holds for the whole access. A slow device can hold the strobe active through a ready input once the programmed minimum width has elapsed. A timeout counter limits how long it can do so. A region that is switched off answers at once and never touches the pins. While an access or its closing pause is running, the request-ready output is low and new start pulses are ignored.

Top module: `bus_cycle_seq`

## Requirements
- R1: The scale code `cfg_mult_i` sets the clock cycles per tick: code 0 gives 4, code 1 gives 1, code 2 gives 2 and code 3 gives 8. The prescaler restarts at the entry of each phase.
- R2: An accepted access runs these phases in order. In address setup, `bus_addr` is driven and `bus_ce_n` is high. Then come the enable-to-strobe delay with `bus_ce_n` low, the strobe, and the hold, where the strobe is high and `bus_ce_n` is still low. The access ends with a pause in which every pin is idle and `bus_addr` is zero.
- R3: A timing field holding N lasts N+1 ticks. `done_o` is high in the first cycle after the hold phase ends, so that many cycles after the accepting edge.
- R4: A read uses `tim_oe_i` for the strobe (`bus_oe_n` low) and `tim_rdh_i` for the hold. A write uses `tim_we_i` (`bus_we_n` low) and `tim_wrh_i`. For a write, `bus_doe` is high and `bus_dout` equals the write data from address setup through hold.
- R5: Read data is sampled from `bus_din` at the clock edge where `bus_oe_n` returns high. It stays on `rdata_o` until the next access.
- R6: With `cfg_wmode_i` set, the strobe does not end at its minimum width while the synchronised `bus_rdy` is low. Once ready is seen high, the strobe stays active for a further `tim_wait_i`+1 ticks. With `cfg_wmode_i` clear, `bus_rdy` has no effect on the strobe width.
- R7: If a ready stretch lasts 1024 cycles, the strobe ends, the access finishes through hold, and `err_o` is high in the same cycle as `done_o`. Otherwise `err_o` stays low.
- R8: With `cfg_en_i` low at acceptance, `done_o` is high in the cycle after the accepting edge. `rdata_o` is zero, and no pin leaves its idle state: enables high, `bus_doe` low.
- R9: `ready_o` is low from the accepting edge until the pause phase ends, for (sum of phases)+(`tim_pause_i`+1) ticks. A start pulse seen while it is low starts nothing.
- R10: `bus_oe_n` and `bus_we_n` are never both low, and neither is low while `bus_ce_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request an access (taken when `ready_o` is high) |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Access address |
| wdata_i | input | DW | Write data |
| ready_o | output | 1 | Sequencer can accept a request |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Ready-stretch timeout, valid with `done_o` |
| rdata_o | output | DW | Sampled read data |
| cfg_en_i | input | 1 | Region enable |
| cfg_mult_i | input | 2 | Tick scale code |
| cfg_wmode_i | input | 1 | Device-ready stretching on |
| tim_adr_i | input | FW | Address setup ticks minus one |
| tim_ce_i | input | FW | Enable-to-strobe ticks minus one |
| tim_oe_i | input | FW | Read strobe ticks minus one |
| tim_we_i | input | FW | Write strobe ticks minus one |
| tim_rdh_i | input | FW | Read hold ticks minus one |
| tim_wrh_i | input | FW | Write hold ticks minus one |
| tim_wait_i | input | FW | Strobe ticks after ready returns, minus one |
| tim_pause_i | input | FW | Pause ticks minus one |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_addr | output | AW | Address pins |
| bus_dout | output | DW | Write data pins |
| bus_doe | output | 1 | Data pin drive enable |
| bus_din | input | DW | Read data pins |
| bus_rdy | input | 1 | Device ready |

## Verification
The bench uses the defaults: 16-bit address and data, 6-bit timing fields, a two-stage ready synchroniser and a 10-bit timeout counter. A 10-bit timeout puts a full timeout within the run, so the error path and its pairing with done are exercised directly. Field values up to 3, with all four scale codes, keep each random access short. This leaves room for many accesses that mix read and write hold and strobe fields, wait extensions, disabled regions and start pulses arriving mid-access.

// File: rtl/bcs_pkg.sv
// Shared types for the chip-select bus cycle sequencer.
// Assumes every timing field has the same width, FIELD_W.
package bcs_pkg;
    parameter int FIELD_W = 6;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CE,
        PH_STROBE,
        PH_WAIT,
        PH_HOLD,
        PH_PAUSE
    } phase_e;

    typedef struct packed {
        logic [FIELD_W-1:0] adr;
        logic [FIELD_W-1:0] ce;
        logic [FIELD_W-1:0] oe;
        logic [FIELD_W-1:0] we;
        logic [FIELD_W-1:0] rdh;
        logic [FIELD_W-1:0] wrh;
        logic [FIELD_W-1:0] wt;
        logic [FIELD_W-1:0] pause;
        logic [1:0]         mult;
        logic               wmode;
    } bcs_cfg_t;
endpackage

// File: rtl/bcs_tick_gen.sv
// Tick prescaler. A 2-bit code picks 4, 1, 2 or 8 clocks per tick.
// Assumes restart is pulsed on the edge that enters a new phase.
module bcs_tick_gen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] code,
    output logic       tick
);
    localparam int PRE_W = 3;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;

    // Map the scale code to (cycles per tick - 1).
    always_comb begin
        case (code)
            2'd0:    lim = PRE_W'(3);
            2'd1:    lim = PRE_W'(0);
            2'd2:    lim = PRE_W'(1);
            default: lim = PRE_W'(7);
        endcase
    end

    assign tick = (pre_q == lim);

    // Count clocks within a tick, restarting on each phase entry.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) pre_q <= '0;
        else                           pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/bcs_sync.sv
// Multi-flop synchroniser for an asynchronous level input.
// Assumes STAGES >= 2; the output resets to RST_VAL.
module bcs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/bcs_phase_cnt.sv
// Tick counter for one phase; flags the tick that completes limit+1 ticks.
// Assumes clear is pulsed on the edge that enters a new phase.
module bcs_phase_cnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt_q;

    assign last = tick && (cnt_q == limit);

    // Count ticks since the phase began.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (tick)       cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/bus_cycle_seq.sv
// One-region external bus access sequencer. On an accepted start it captures
// the configuration and runs address setup, enable-to-strobe, strobe
// (optionally stretched by device ready, then extended), hold and pause.
// Assumes the configuration inputs are valid in the cycle start is taken.
module bus_cycle_seq #(
    parameter int AW     = 16,
    parameter int DW     = 16,
    parameter int FW     = bcs_pkg::FIELD_W,
    parameter int SYNC_N = 2,
    parameter int TMO_W  = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          write_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          ready_o,
    output logic          done_o,
    output logic          err_o,
    output logic [DW-1:0] rdata_o,
    input  logic          cfg_en_i,
    input  logic [1:0]    cfg_mult_i,
    input  logic          cfg_wmode_i,
    input  logic [FW-1:0] tim_adr_i,
    input  logic [FW-1:0] tim_ce_i,
    input  logic [FW-1:0] tim_oe_i,
    input  logic [FW-1:0] tim_we_i,
    input  logic [FW-1:0] tim_rdh_i,
    input  logic [FW-1:0] tim_wrh_i,
    input  logic [FW-1:0] tim_wait_i,
    input  logic [FW-1:0] tim_pause_i,
    output logic          bus_ce_n,
    output logic          bus_oe_n,
    output logic          bus_we_n,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    output logic          bus_doe,
    input  logic [DW-1:0] bus_din,
    input  logic          bus_rdy
);
    import bcs_pkg::*;

    localparam logic [TMO_W-1:0] TMO_LAST = {TMO_W{1'b1}};

    phase_e           ph_q, ph_nx;
    bcs_cfg_t         cfg_q;
    logic             wr_q, min_done_q, terr_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    wdata_q, rdata_q;
    logic             done_q, err_q;
    logic [TMO_W-1:0] tmo_q;
    logic [FW-1:0]    lim;
    logic             accept, adv, tick, last, rdy_s;
    logic             stb_ok, stretch, tmo_hit, in_cycle, strobe_on, capture;

    assign accept = start_i && (ph_q == PH_IDLE);

    bcs_tick_gen u_tick (
        .clk(clk), .rst_n(rst_n), .restart(adv || accept),
        .code(cfg_q.mult), .tick(tick)
    );

    bcs_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_rdy), .q(rdy_s)
    );

    bcs_phase_cnt #(.W(FW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(adv || accept),
        .tick(tick), .limit(lim), .last(last)
    );

    // Pick the tick limit of the current phase by direction.
    always_comb begin
        case (ph_q)
            PH_ADDR:   lim = cfg_q.adr;
            PH_CE:     lim = cfg_q.ce;
            PH_STROBE: lim = wr_q ? cfg_q.we : cfg_q.oe;
            PH_WAIT:   lim = cfg_q.wt;
            PH_HOLD:   lim = wr_q ? cfg_q.wrh : cfg_q.rdh;
            PH_PAUSE:  lim = cfg_q.pause;
            default:   lim = '0;
        endcase
    end

    assign stb_ok  = last || min_done_q;
    assign stretch = (ph_q == PH_STROBE) && stb_ok && cfg_q.wmode && !rdy_s;
    assign tmo_hit = stretch && (tmo_q == TMO_LAST);

    // Decide when the current phase ends and which phase follows.
    always_comb begin
        adv   = 1'b0;
        ph_nx = ph_q;
        case (ph_q)
            PH_ADDR:   begin adv = last; ph_nx = PH_CE; end
            PH_CE:     begin adv = last; ph_nx = PH_STROBE; end
            PH_STROBE: begin
                adv   = stb_ok && (!cfg_q.wmode || rdy_s || tmo_hit);
                ph_nx = (cfg_q.wmode && !tmo_hit) ? PH_WAIT : PH_HOLD;
            end
            PH_WAIT:   begin adv = last; ph_nx = PH_HOLD; end
            PH_HOLD:   begin adv = last; ph_nx = PH_PAUSE; end
            PH_PAUSE:  begin adv = last; ph_nx = PH_IDLE; end
            default:   begin adv = 1'b0; ph_nx = PH_IDLE; end
        endcase
    end

    assign capture = adv && !wr_q && (ph_nx == PH_HOLD);

    // Phase register and captured access context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= PH_IDLE;
            cfg_q   <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept && cfg_en_i) begin
            ph_q    <= PH_ADDR;
            wr_q    <= write_i;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            cfg_q   <= '{adr: tim_adr_i, ce: tim_ce_i, oe: tim_oe_i,
                         we: tim_we_i, rdh: tim_rdh_i, wrh: tim_wrh_i,
                         wt: tim_wait_i, pause: tim_pause_i,
                         mult: cfg_mult_i, wmode: cfg_wmode_i};
        end else if (adv) begin
            ph_q <= ph_nx;
        end
    end

    // Minimum strobe width reached, ready-stretch timeout and error memory.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            min_done_q <= 1'b0;
            tmo_q      <= '0;
            terr_q     <= 1'b0;
        end else begin
            min_done_q <= (ph_q == PH_STROBE) && stb_ok && !adv;
            tmo_q      <= (stretch && !tmo_hit) ? tmo_q + 1'b1 : '0;
            if (tmo_hit) terr_q <= 1'b1;
        end
    end

    // Completion pulse, error flag and read data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= (accept && !cfg_en_i) || ((ph_q == PH_HOLD) && adv);
            err_q  <= (ph_q == PH_HOLD) && adv && terr_q;
            if (accept && !cfg_en_i) rdata_q <= '0;
            else if (capture)        rdata_q <= bus_din;
        end
    end

    assign in_cycle  = (ph_q == PH_ADDR) || (ph_q == PH_CE) || (ph_q == PH_STROBE)
                    || (ph_q == PH_WAIT) || (ph_q == PH_HOLD);
    assign strobe_on = (ph_q == PH_STROBE) || (ph_q == PH_WAIT);

    assign ready_o  = (ph_q == PH_IDLE);
    assign done_o   = done_q;
    assign err_o    = err_q;
    assign rdata_o  = rdata_q;
    assign bus_ce_n = !(in_cycle && (ph_q != PH_ADDR));
    assign bus_oe_n = !(strobe_on && !wr_q);
    assign bus_we_n = !(strobe_on && wr_q);
    assign bus_addr = in_cycle ? addr_q : '0;
    assign bus_dout = wdata_q;
    assign bus_doe  = in_cycle && wr_q;
endmodule

// File: rtl/bus_cycle_seq_chk.sv
// Temporal checks on the pins of bus_cycle_seq, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module bus_cycle_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ready_o,
    input logic done_o,
    input logic err_o,
    input logic bus_ce_n,
    input logic bus_oe_n,
    input logic bus_we_n,
    input logic bus_doe
);
    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_oe_n && !bus_we_n));

    // R10
    strobe_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_oe_n || !bus_we_n) |-> !bus_ce_n);

    // R7
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    // R9
    ce_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ce_n |-> !ready_o);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (bus_ce_n && bus_oe_n && bus_we_n && !bus_doe));

    // R4
    wdata_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_n |-> bus_doe);

    // R2
    strobe_after_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_oe_n) || $fell(bus_we_n)) |-> $past(!bus_ce_n));
endmodule

bind bus_cycle_seq bus_cycle_seq_chk u_bus_cycle_seq_chk (
    .clk(clk), .rst_n(rst_n), .ready_o(ready_o), .done_o(done_o),
    .err_o(err_o), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
    .bus_we_n(bus_we_n), .bus_doe(bus_doe)
);

// File: tb/bus_cycle_seq_bench.sv
// Self-checking bench: directed corners plus seeded random accesses.
module bus_cycle_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, write_i = 1'b0;
    logic [15:0] addr_i = '0, wdata_i = '0;
    logic        ready_o, done_o, err_o;
    logic [15:0] rdata_o;
    logic        cfg_en_i = 1'b1, cfg_wmode_i = 1'b0;
    logic [1:0]  cfg_mult_i = 2'd1;
    logic [5:0]  t_adr = 0, t_ce = 0, t_oe = 0, t_we = 0, t_rdh = 0, t_wrh = 0, t_wt = 0, t_pause = 0;
    logic        bus_ce_n, bus_oe_n, bus_we_n, bus_doe;
    logic [15:0] bus_addr, bus_dout, bus_din;
    logic        rdy_drv = 1'b1;

    int n_chk = 0, n_fail = 0;
    // results of the last access
    int r_lat, r_ce, r_stb, r_setup, r_busy, r_falls, r_ndone, r_wbad, r_abad, r_pinbad;
    logic r_err;
    logic [15:0] r_rd;

    always #2 clk = ~clk;

    assign bus_din = bus_oe_n ? 16'hDEAD : (bus_addr ^ 16'h5A3C);

    bus_cycle_seq u_bus_cycle_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .ready_o(ready_o), .done_o(done_o),
        .err_o(err_o), .rdata_o(rdata_o), .cfg_en_i(cfg_en_i),
        .cfg_mult_i(cfg_mult_i), .cfg_wmode_i(cfg_wmode_i),
        .tim_adr_i(t_adr), .tim_ce_i(t_ce), .tim_oe_i(t_oe), .tim_we_i(t_we),
        .tim_rdh_i(t_rdh), .tim_wrh_i(t_wrh), .tim_wait_i(t_wt),
        .tim_pause_i(t_pause), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
        .bus_we_n(bus_we_n), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_din(bus_din), .bus_rdy(rdy_drv)
    );

    function automatic int mcyc(input logic [1:0] c);
        case (c)
            2'd0: return 4;
            2'd1: return 1;
            2'd2: return 2;
            default: return 8;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Run one request; poke re-issues start with another address in cycles 3..6.
    task automatic run_one(input bit wr, input logic [15:0] a, input logic [15:0] wd,
                           input int rdy_rise, input bit poke);
        int k, s;
        bit got, prev_ce;
        r_ce = 0; r_stb = 0; r_setup = 0; r_busy = 0; r_falls = 0; r_ndone = 0;
        r_wbad = 0; r_abad = 0; r_pinbad = 0; r_lat = -1; r_err = 1'b0; r_rd = '0;
        got = 1'b0; s = 0; prev_ce = 1'b1;
        @(negedge clk);
        start_i = 1'b1; write_i = wr; addr_i = a; wdata_i = wd;
        @(negedge clk);
        start_i = 1'b0;
        k = 1;
        while (k < 5000) begin
            if (!bus_ce_n) r_ce++;
            if (prev_ce && !bus_ce_n) r_falls++;
            prev_ce = bus_ce_n;
            if (!bus_oe_n || !bus_we_n) begin
                r_stb++; s++;
                if (bus_addr != a) r_abad++;
            end
            if (bus_ce_n && !ready_o && bus_addr == a) r_setup++;
            if (!ready_o) r_busy++;
            if (!bus_we_n && (!bus_doe || bus_dout != wd)) r_wbad++;
            if (wr ? !bus_oe_n : !bus_we_n) r_pinbad++;
            if (ready_o && (!bus_ce_n || bus_doe)) r_pinbad++;
            if (rdy_rise > 0 && s == rdy_rise) rdy_drv = 1'b1;
            if (done_o) begin
                r_ndone++;
                if (!got) begin got = 1'b1; r_lat = k; r_err = err_o; r_rd = rdata_o; end
            end
            if (got && ready_o) break;
            if (poke && k >= 3 && k <= 6) begin start_i = 1'b1; addr_i = ~a; end
            else if (poke) start_i = 1'b0;
            @(negedge clk);
            k++;
        end
        start_i = 1'b0;
    endtask

    // Compare the last access against expectations derived from the fields.
    task automatic check_timing(input bit wr, input logic [15:0] a, input string tag);
        int m, stb, hld, d, expstb;
        m      = mcyc(cfg_mult_i);
        stb    = wr ? int'(t_we) : int'(t_oe);
        hld    = wr ? int'(t_wrh) : int'(t_rdh);
        expstb = (stb + 1 + (cfg_wmode_i ? int'(t_wt) + 1 : 0)) * m;
        d      = (int'(t_adr) + 1 + int'(t_ce) + 1 + int'(t_rdh - t_rdh) + hld + 1) * m + expstb;
        chk(r_lat == d + 1, {tag, " R3 latency"}, r_lat, d + 1);
        chk(r_stb == expstb, {tag, " R4/R1 strobe width"}, r_stb, expstb);
        chk(r_ce == d - (int'(t_adr) + 1) * m, {tag, " R2 ce width"}, r_ce, d - (int'(t_adr) + 1) * m);
        chk(r_setup == (int'(t_adr) + 1) * m, {tag, " R2 addr setup"}, r_setup, (int'(t_adr) + 1) * m);
        chk(r_busy == d + (int'(t_pause) + 1) * m, {tag, " R9 busy span"}, r_busy, d + (int'(t_pause) + 1) * m);
        chk(r_pinbad == 0 && r_abad == 0, {tag, " R4 pin use"}, r_pinbad + r_abad, 0);
        chk(r_err == 1'b0, {tag, " R7 no error"}, int'(r_err), 0);
        if (wr) chk(r_wbad == 0, {tag, " R4 write data"}, r_wbad, 0);
        else    chk(r_rd == (a ^ 16'h5A3C), {tag, " R5 read data"}, int'(r_rd), int'(a ^ 16'h5A3C));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [15:0] a, wd;
        bit wr;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state: idle pins, ready high
        chk(ready_o && bus_ce_n && bus_oe_n && bus_we_n && !bus_doe && !done_o,
            "R8 reset idle", int'(ready_o), 1);

        // R1 each scale code, read, no wait
        t_adr = 1; t_ce = 0; t_oe = 2; t_rdh = 1; t_pause = 1; t_we = 3; t_wrh = 2;
        for (int c = 0; c < 4; c++) begin
            cfg_mult_i = 2'(c);
            run_one(1'b0, 16'h1230 + 16'(c), 16'h0, 0, 1'b0);
            check_timing(1'b0, 16'h1230 + 16'(c), "R1 scale");
        end

        // R4 write uses its own strobe and hold fields
        cfg_mult_i = 2'd2; t_we = 4; t_wrh = 3; t_oe = 0; t_rdh = 0;
        run_one(1'b1, 16'h4321, 16'hBEEF, 0, 1'b0);
        check_timing(1'b1, 16'h4321, "R4 write");

        // R8 disabled region: immediate done, no pins, zero data
        cfg_en_i = 1'b0;
        run_one(1'b0, 16'h0777, 16'h0, 0, 1'b0);
        chk(r_lat == 1, "R8 disabled latency", r_lat, 1);
        chk(r_falls == 0 && r_stb == 0 && r_busy == 0, "R8 no pin activity", r_falls + r_stb + r_busy, 0);
        chk(r_rd == 16'h0, "R8 read zero", int'(r_rd), 0);
        run_one(1'b1, 16'h0778, 16'h1111, 0, 1'b0);
        chk(r_falls == 0 && r_stb == 0 && r_pinbad == 0, "R8 disabled write quiet", r_falls + r_stb, 0);
        cfg_en_i = 1'b1;

        // R6 ready ignored without wait mode
        cfg_mult_i = 2'd1; cfg_wmode_i = 1'b0; t_oe = 3; rdy_drv = 1'b0;
        run_one(1'b0, 16'h2001, 16'h0, 0, 1'b0);
        check_timing(1'b0, 16'h2001, "R6 no wait mode");
        rdy_drv = 1'b1;

        // R6 stretch: ready low until 20 strobe cycles, then wait ticks follow
        cfg_wmode_i = 1'b1; t_oe = 1; t_wt = 2; rdy_drv = 1'b0;
        run_one(1'b0, 16'h2002, 16'h0, 20, 1'b0);
        chk(r_stb >= 23 && r_stb <= 27, "R6 stretched strobe", r_stb, 25);
        chk(r_err == 1'b0 && r_rd == (16'h2002 ^ 16'h5A3C), "R6 stretched read", int'(r_rd), int'(16'h2002 ^ 16'h5A3C));
        rdy_drv = 1'b1;

        // R7 timeout: ready never returns
        t_oe = 0; rdy_drv = 1'b0;
        run_one(1'b0, 16'h2003, 16'h0, 0, 1'b0);
        chk(r_err == 1'b1, "R7 timeout error", int'(r_err), 1);
        chk(r_stb >= 1023 && r_stb <= 1027, "R7 timeout width", r_stb, 1024);
        chk(r_ndone == 1, "R7 single done", r_ndone, 1);
        rdy_drv = 1'b1; cfg_wmode_i = 1'b0;

        // R9 start pulses while busy are ignored
        cfg_mult_i = 2'd3; t_adr = 3; t_oe = 1;
        run_one(1'b0, 16'h3003, 16'h0, 0, 1'b1);
        chk(r_falls == 1 && r_ndone == 1, "R9 one access only", r_falls * 10 + r_ndone, 11);
        chk(r_abad == 0, "R9 address kept", r_abad, 0);
        check_timing(1'b0, 16'h3003, "R9 holdoff");

        // Random accesses over all fields and codes
        for (int i = 0; i < 40; i++) begin
            cfg_mult_i = 2'($urandom_range(0, 3));
            cfg_wmode_i = 1'($urandom_range(0, 1));
            t_adr = 6'($urandom_range(0, 3)); t_ce = 6'($urandom_range(0, 3));
            t_oe = 6'($urandom_range(0, 3));  t_we = 6'($urandom_range(0, 3));
            t_rdh = 6'($urandom_range(0, 3)); t_wrh = 6'($urandom_range(0, 3));
            t_wt = 6'($urandom_range(0, 3));  t_pause = 6'($urandom_range(0, 3));
            wr = 1'($urandom_range(0, 1));
            a  = 16'($urandom) | 16'h1;
            wd = 16'($urandom);
            run_one(wr, a, wd, 0, 1'b0);
            check_timing(wr, a, "random R1 R6");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule